// File: doc/BRIEF.md
# Single-Slope PWM Timer with Compare Output

This block is an 8-bit up-counting timer that generates one pulse-width-modulated waveform. A prescaler divides the system clock by a selectable factor, and each resulting tick advances the counter from 0 to 255. On the tick after 255 the counter returns to 0, so one period lasts 256 ticks. When the counter reaches 255 an overflow flag is raised. The flag stays set until software clears it by writing a one.

A compare value is written through a small write port. The value first goes into a holding buffer and becomes active only when the counter reaches 255. This keeps every period on a single compare value. A two-bit output-mode field selects what the output pin does: held low, toggling on each compare match, non-inverted PWM or inverted PWM. The compare write port carries a valid strobe and no ready signal, because the block accepts a write on every cycle and never applies back-pressure. All other pins are plain level signals.

Top module: `fpwm_timer`

## Requirements
- R1: The counter advances by one on each prescaled tick, from 0 up to 255, and goes back to 0 on the tick after 255. After reset with divide-by-1 selected, the overflow flag is still low after 254 clock edges and is high after the 255th edge.
- R2: `presc_sel` selects the tick divider: 0 gives 1, 1 gives 8, 2 gives 64, 3 gives 256, and 4 to 7 give 1024. The divider restarts from zero whenever the selection changes. The counter period is 256 times the divider, counted in system clocks.
- R3: `ovf_flag` rises on the tick on which the counter becomes 255. It stays high until `ovf_clr` is asserted. If a clear and a set fall in the same cycle, the set wins, so holding `ovf_clr` high leaves the flag visible for exactly one cycle per period.
- R4: A value written through `cmp_wr_valid`/`cmp_wr_data` is held in a buffer. It becomes the active compare value only when the counter reaches 255. A write made in the middle of a period does not change the output during the rest of that period.
- R5: With `out_mode` = 2 (non-inverted), the output goes high when the counter wraps to 0. It goes low on the tick after the counter has equalled the compare value C, so it is high for C+1 ticks in each period. C = 0 gives a one-tick spike and C = 255 gives a constant high.
- R6: With `out_mode` = 3 (inverted), the output is the complement of R5. It is low at the wrap and goes high after the match, so it is high for 255−C ticks. C = 255 gives a constant low and C = 0 gives a high level with a one-tick dip.
- R7: With `out_mode` = 1 (toggle), the output flips on each tick at which the counter equals C. This gives a 50% duty square wave with a period of 512 ticks.
- R8: With `out_mode` = 0, the output is held low one cycle later and stays low. The counter and the overflow flag keep running.
- R9: Reset (`rst_n` low) clears the counter, the buffered and active compare values, the output and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_sel | input | 3 | Tick divider select (see R2) |
| cmp_wr_valid | input | 1 | Compare write strobe, always accepted |
| cmp_wr_data | input | 8 | Compare value to buffer |
| out_mode | input | 2 | Output mode: 0 off, 1 toggle, 2 non-inverted, 3 inverted |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| pwm_out | output | 1 | Waveform output |

## Verification
Two pairs of events can land on the same tick, and both need a defined winner. The first pair is the hardware set and the software clear of the overflow flag. The bench holds `ovf_clr` high across a whole period, so one clear is certain to meet the set. It then requires the flag to be seen high on exactly one sampled cycle. The second pair is the wrap to zero and a compare match at 255. The bench loads 255 in both PWM polarities and expects a fixed level over two full periods. That means 512 high samples in non-inverted mode and none in inverted mode. A bound property also checks directly that the wrap wins in non-inverted mode.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam int CNT_W = 8;
  localparam int DIV_W = 10;

  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_NONINV = 2'd2,
    OM_INV    = 2'd3
  } outmode_e;
endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler #(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [2:0]       sel_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;
  logic             changed;

  // terminal count for the selected divider
  always_comb begin
    case (sel)
      3'd0:    lim = DIV_W'(0);
      3'd1:    lim = DIV_W'(7);
      3'd2:    lim = DIV_W'(63);
      3'd3:    lim = DIV_W'(255);
      default: lim = DIV_W'(1023);
    endcase
  end

  assign changed = (sel != sel_q);
  assign tick    = !changed && (div_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 3'd0;
      div_q <= '0;
    end else begin
      sel_q <= sel;
      if (changed || tick) div_q <= '0;
      else                 div_q <= div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/fpwm_count.sv
module fpwm_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_valid,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp_act,
  output logic             max_evt,
  output logic             ovf_flag
);
  localparam logic [CNT_W-1:0] TOP    = '1;
  localparam logic [CNT_W-1:0] PRETOP = TOP - CNT_W'(1);

  logic [CNT_W-1:0] cmp_buf;

  // the counter is about to reach TOP on this tick
  assign max_evt = tick && (cnt == PRETOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      cmp_buf  <= '0;
      cmp_act  <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (tick) cnt <= (cnt == TOP) ? '0 : cnt + CNT_W'(1);
      if (wr_valid) cmp_buf <= wr_data;
      if (max_evt) cmp_act <= cmp_buf;
      // a set in the same cycle as a clear takes priority
      if (max_evt)      ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/fpwm_wave.sv
module fpwm_wave #(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [CNT_W-1:0]    cmp_act,
  input  fpwm_pkg::outmode_e  mode,
  output logic                wave
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic wrap;
  logic match;

  assign wrap  = tick && (cnt == TOP);
  assign match = tick && (cnt == cmp_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave <= 1'b0;
    end else begin
      case (mode)
        fpwm_pkg::OM_OFF:    wave <= 1'b0;
        fpwm_pkg::OM_TOGGLE: if (match) wave <= !wave;
        fpwm_pkg::OM_NONINV: begin
          if (wrap)       wave <= 1'b1;
          else if (match) wave <= 1'b0;
        end
        default: begin
          if (wrap)       wave <= 1'b0;
          else if (match) wave <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] presc_sel,
  input  logic       cmp_wr_valid,
  input  logic [7:0] cmp_wr_data,
  input  logic [1:0] out_mode,
  input  logic       ovf_clr,
  output logic       ovf_flag,
  output logic       pwm_out
);
  localparam int CW = fpwm_pkg::CNT_W;
  localparam int DW = fpwm_pkg::DIV_W;

  logic          tick;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cmp_act;
  logic          max_evt;
  fpwm_pkg::outmode_e mode_e;

  assign mode_e = fpwm_pkg::outmode_e'(out_mode);

  fpwm_prescaler #(.DIV_W(DW)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (presc_sel),
    .tick  (tick)
  );

  fpwm_count #(.CNT_W(CW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_valid (cmp_wr_valid),
    .wr_data  (cmp_wr_data),
    .ovf_clr  (ovf_clr),
    .cnt      (cnt),
    .cmp_act  (cmp_act),
    .max_evt  (max_evt),
    .ovf_flag (ovf_flag)
  );

  fpwm_wave #(.CNT_W(CW)) u_wave (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cnt     (cnt),
    .cmp_act (cmp_act),
    .mode    (mode_e),
    .wave    (pwm_out)
  );
endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [7:0] cnt,
  input logic [7:0] cmp_act,
  input logic       max_evt,
  input logic [1:0] out_mode,
  input logic       ovf_clr,
  input logic       ovf_flag,
  input logic       pwm_out
);
  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == 8'hFF) |=> (cnt == 8'h00));

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != 8'hFF) |=> (cnt == 8'($past(cnt) + 8'd1)));

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    max_evt |=> ovf_flag);

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R4
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !max_evt |=> $stable(cmp_act));

  // R5
  noninv_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'd2 && tick && cnt == 8'hFF && cmp_act == 8'hFF) |=> pwm_out);

  // R8
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'd0) |=> !pwm_out);
endmodule

bind fpwm_timer fpwm_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .cnt      (cnt),
  .cmp_act  (cmp_act),
  .max_evt  (max_evt),
  .out_mode (out_mode),
  .ovf_clr  (ovf_clr),
  .ovf_flag (ovf_flag),
  .pwm_out  (pwm_out)
);

// File: tb/sim_fpwm_timer.sv
module sim_fpwm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int NVEC       = 9;
  // {mode[1:0], compare[7:0], expected highs over 512 ticks[9:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {2'd2, 8'd0,   10'd2},
    {2'd2, 8'd100, 10'd202},
    {2'd2, 8'd255, 10'd512},
    {2'd3, 8'd0,   10'd510},
    {2'd3, 8'd100, 10'd310},
    {2'd3, 8'd255, 10'd0},
    {2'd1, 8'd37,  10'd256},
    {2'd0, 8'd100, 10'd0},
    {2'd2, 8'd254, 10'd510}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] presc_sel = 3'd0;
  logic       cmp_wr_valid = 1'b0;
  logic [7:0] cmp_wr_data = 8'd0;
  logic [1:0] out_mode = 2'd0;
  logic       ovf_clr = 1'b0;
  logic       ovf_flag;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  fpwm_timer u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .presc_sel    (presc_sel),
    .cmp_wr_valid (cmp_wr_valid),
    .cmp_wr_data  (cmp_wr_data),
    .out_mode     (out_mode),
    .ovf_clr      (ovf_clr),
    .ovf_flag     (ovf_flag),
    .pwm_out      (pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cmp(input logic [7:0] v);
    cmp_wr_valid = 1'b1;
    cmp_wr_data  = v;
    @(negedge clk);
    cmp_wr_valid = 1'b0;
  endtask

  task automatic clear_ovf();
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
  endtask

  task automatic wait_ovf();
    while (!ovf_flag) @(negedge clk);
  endtask

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'd0:    return "R8";
      2'd1:    return "R7";
      2'd2:    return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int highs;
    int bad;
    int t0;
    int t1;
    // R9 reset state
    repeat (3) @(negedge clk);
    check(ovf_flag == 1'b0, "R9 flag in reset", ovf_flag, 0);
    check(pwm_out == 1'b0, "R9 output in reset", pwm_out, 0);
    rst_n = 1'b1;
    // R1 overflow timing from reset
    repeat (254) @(posedge clk);
    @(negedge clk);
    check(ovf_flag == 1'b0, "R1 flag before 255th edge", ovf_flag, 0);
    @(posedge clk);
    @(negedge clk);
    check(ovf_flag == 1'b1, "R1 flag at 255th edge", ovf_flag, 1);

    // table of mode/compare vectors
    for (int i = 0; i < NVEC; i++) begin
      out_mode = VEC[i][19:18];
      write_cmp(VEC[i][17:10]);
      clear_ovf();
      wait_ovf();
      repeat (256) @(negedge clk);
      highs = 0;
      repeat (512) begin
        @(negedge clk);
        if (pwm_out) highs++;
      end
      check(highs == int'(VEC[i][9:0]), mode_req(VEC[i][19:18]), highs, int'(VEC[i][9:0]));
    end

    // R9 mid-run reset clears counter, compare and output
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(ovf_flag == 1'b0 && pwm_out == 1'b0, "R9 mid-run reset", {ovf_flag, pwm_out}, 0);
    rst_n = 1'b1;
    repeat (254) @(posedge clk);
    @(negedge clk);
    check(ovf_flag == 1'b0, "R9 counter restarted", ovf_flag, 0);
    @(posedge clk);
    @(negedge clk);
    check(ovf_flag == 1'b1, "R9 counter restarted", ovf_flag, 1);
    @(posedge clk);
    @(negedge clk);
    check(pwm_out == 1'b1, "R9 spike after wrap", pwm_out, 1);
    @(posedge clk);
    @(negedge clk);
    check(pwm_out == 1'b0, "R9 compare reset to zero", pwm_out, 0);

    // R4 buffered compare
    write_cmp(8'd255);
    clear_ovf();
    wait_ovf();
    clear_ovf();
    repeat (100) @(negedge clk);
    write_cmp(8'd0);
    bad = 0;
    while (!ovf_flag) begin
      if (!pwm_out) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R4 old compare kept", bad, 0);
    @(negedge clk);
    check(pwm_out == 1'b1, "R4 wrap sets output", pwm_out, 1);
    @(negedge clk);
    check(pwm_out == 1'b0, "R4 new compare active", pwm_out, 0);

    // R3 set wins over held clear
    clear_ovf();
    ovf_clr = 1'b1;
    highs = 0;
    repeat (256) begin
      @(negedge clk);
      if (ovf_flag) highs++;
    end
    ovf_clr = 1'b0;
    check(highs == 1, "R3 set beats clear", highs, 1);
    wait_ovf();
    repeat (300) @(negedge clk);
    check(ovf_flag == 1'b1, "R3 flag sticky", ovf_flag, 1);

    // R8 counter keeps running while output is off
    out_mode = 2'd0;
    clear_ovf();
    t0 = cyc;
    wait_ovf();
    check((cyc - t0) <= 257, "R8 counter runs when off", cyc - t0, 256);
    check(pwm_out == 1'b0, "R8 output low", pwm_out, 0);

    // R2 divider periods
    presc_sel = 3'd1;
    clear_ovf();
    wait_ovf();
    t0 = cyc;
    clear_ovf();
    wait_ovf();
    t1 = cyc;
    check((t1 - t0) == 2048, "R2 divide by 8", t1 - t0, 2048);
    presc_sel = 3'd2;
    clear_ovf();
    wait_ovf();
    t0 = cyc;
    clear_ovf();
    wait_ovf();
    t1 = cyc;
    check((t1 - t0) == 16384, "R2 divide by 64", t1 - t0, 16384);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule